// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a 512-byte on-chip register array. The array behaves like nonvolatile memory: data sent by a bus master is gathered in a 16-byte page buffer and committed to the array only when the master closes the transfer with a stop condition. A self-timed write cycle follows, during which the slave ignores the bus. Both bus lines are synchronised to the system clock and sampled. Start and stop conditions are detected from the sampled lines. The slave answers only when the address byte carries its fixed device-type code and the values of its two strap pins. It acknowledges and returns read data by asserting an open-drain pull-down enable.

The ninth address bit travels in the slave-address byte, and the low eight bits come from a word-address byte in write transfers. An internal address counter serves current-address reads and sequential reads. A write transfer that sends only a word address and no data (a "dummy write") loads the counter without starting a write cycle, so that a following read starts at that address.

Protocol states: `ST_IDLE` (waiting for start), `ST_DEV` (shifting the slave-address byte), `ST_DEV_ACK`, `ST_WORD` (shifting the word address), `ST_WORD_ACK`, `ST_WDATA` (shifting a data byte), `ST_WDATA_ACK`, `ST_RDATA` (shifting a byte out), `ST_RD_ACK` (master acknowledge slot), `ST_COMMIT` (page buffer to array) and `ST_BUSY` (timed write cycle). Transitions are as follows. A start in any bus state goes to `ST_DEV`. A stop in a bus state goes to `ST_COMMIT` if data is buffered, and to `ST_IDLE` otherwise. `ST_DEV` goes to `ST_DEV_ACK` on a match or back to `ST_IDLE` on a mismatch. `ST_DEV_ACK` goes to `ST_RDATA` for a read or to `ST_WORD` for a write. `ST_WORD` goes to `ST_WORD_ACK` and then to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` alternate. `ST_RDATA` goes to `ST_RD_ACK`, which returns to `ST_RDATA` on a master ACK or goes to `ST_IDLE` on a NACK. `ST_COMMIT` goes to `ST_BUSY` after sweeping the page, and `ST_BUSY` goes to `ST_IDLE` when its count expires.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the pull-down enable is low, every array location reads 0xFF and the address counter is 0.
- R2: The slave-address byte is sent MSB first. Bits 7:4 must be 1010, bit 3 must equal strap_i[1] and bit 2 must equal strap_i[0]. Bit 1 is array address bit 8, and bit 0 selects read (1) or write (0). On a mismatch there is no acknowledge, and the rest of the transfer is ignored until the next start.
- R3: In a write, the slave pulls SDA low in the ninth clock after the address byte, after the word-address byte and after each data byte. The byte lands at location {address-byte bit 1, word address}.
- R4: The array changes only after a stop that ends a write carrying data. A repeated start discards buffered data. A stop after only a word address starts no write cycle.
- R5: In a write, the low 4 address bits advance per data byte and wrap inside the 16-byte page. Bytes beyond 16 overwrite the earliest ones. Afterwards the counter points at the page slot following the last byte.
- R6: For WR_CYCLES clocks after the committing stop, the slave does not acknowledge its own address and keeps SDA released. After that it acknowledges again.
- R7: A read returns the byte at {address-byte bit 1, counter bits 7:0}, MSB first, with SDA changed only while SCL is low.
- R8: In a read, a master ACK advances the counter (0x1FF wraps to 0x000) and starts the next byte. A master NACK releases SDA, leaves the counter unchanged and ignores the bus until the next start.
- R9: A write transfer holding only a word address, followed by a repeated start, loads the counter for the subsequent read.
- R10: A start seen in the middle of a byte restarts the address phase with a cleared bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 2 | Device-select straps; bit 1 pairs with address-byte bit 3, bit 0 with bit 2 |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench builds the block with WR_CYCLES set to 300 and the default 16-byte page. A timed write cycle therefore completes within a few hundred clocks, and the bench can probe the slave both inside and after the busy window in one run. A 20-byte page write wraps within the page and overwrites earlier bytes, and a single read sweeps across the 0x1FF to 0x000 boundary. A behavioural memory model predicts every acknowledge and every data byte, and a per-clock monitor checks the released line throughout each write cycle.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam int ADDR_W = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_COMMIT,
        ST_BUSY
    } tw_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tw_evt_t;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler
    import tw_eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_s,
    output logic    sda_s,
    output tw_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_comb begin
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
    end

    // Only one bus event per sampled clock; start/stop never pair with an SCL edge.
    assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.start, evt.stop, evt.rise, evt.fall}));

endmodule

// File: rtl/tw_page_buffer.sv
module tw_page_buffer
    import tw_eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [BYTE_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_valid;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[g]  <= '0;
                slot_valid[g] <= 1'b0;
            end else if (clear) begin
                slot_valid[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PAGE_W'(g))) begin
                slot_data[g]  <= wr_data;
                slot_valid[g] <= 1'b1;
            end
        end
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = slot_valid[rd_idx];
    assign any_valid = |slot_valid;

    // A clear leaves nothing pending for the next transfer.
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid);

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array
    import tw_eeprom_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= ERASED;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/tw_eeprom_fsm.sv
module tw_eeprom_fsm
    import tw_eeprom_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE  = 4'b1010,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tw_evt_t           evt,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [1:0]        strap_i,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              buf_clear,
    output logic              buf_wr_en,
    output logic [PAGE_W-1:0] buf_wr_idx,
    output logic [BYTE_W-1:0] buf_wr_data,
    output logic [PAGE_W-1:0] buf_rd_idx,
    input  logic [BYTE_W-1:0] buf_rd_data,
    input  logic              buf_rd_valid,
    input  logic              buf_any,
    output logic              drive_low
);

    localparam int BUSY_W = $clog2(WR_CYCLES + 1);
    localparam int ROW_W  = ADDR_W - PAGE_W;

    tw_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [3:0]        bit_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              hi_q;
    logic              rw_q;
    logic [BYTE_W-1:0] tx_q;
    logic              m_ack_q;
    logic              drive_q;
    logic [PAGE_W-1:0] commit_idx_q;
    logic [BUSY_W-1:0] busy_cnt_q;

    logic              on_bus;
    logic              byte_done;
    logic              addr_match;
    logic              commit_last;
    logic              busy_last;
    logic [2:0]        tx_idx;

    assign on_bus      = (state_q != ST_COMMIT) && (state_q != ST_BUSY);
    assign byte_done   = evt.fall && (bit_cnt_q == 4'd8);
    assign addr_match  = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:2] == strap_i);
    assign commit_last = &commit_idx_q;
    assign busy_last   = (busy_cnt_q == BUSY_W'(WR_CYCLES - 1));
    assign tx_idx      = 3'd7 - bit_cnt_q[2:0];

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = ST_IDLE;
            ST_DEV:       if (byte_done) state_d = addr_match ? ST_DEV_ACK : ST_IDLE;
            ST_DEV_ACK:   if (evt.fall) state_d = rw_q ? ST_RDATA : ST_WORD;
            ST_WORD:      if (byte_done) state_d = ST_WORD_ACK;
            ST_WORD_ACK:  if (evt.fall) state_d = ST_WDATA;
            ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
            ST_WDATA_ACK: if (evt.fall) state_d = ST_WDATA;
            ST_RDATA:     if (byte_done) state_d = ST_RD_ACK;
            ST_RD_ACK:    if (evt.fall) state_d = m_ack_q ? ST_RDATA : ST_IDLE;
            ST_COMMIT:    if (commit_last) state_d = ST_BUSY;
            ST_BUSY:      if (busy_last) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
        if (on_bus) begin
            if (evt.start) begin
                state_d = ST_DEV;
            end else if (evt.stop) begin
                state_d = buf_any ? ST_COMMIT : ST_IDLE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q      <= '0;
            bit_cnt_q    <= '0;
            addr_q       <= '0;
            hi_q         <= 1'b0;
            rw_q         <= 1'b0;
            tx_q         <= '0;
            m_ack_q      <= 1'b0;
            drive_q      <= 1'b0;
            commit_idx_q <= '0;
            busy_cnt_q   <= '0;
        end else if (state_q == ST_COMMIT) begin
            commit_idx_q <= commit_idx_q + 1'b1;
            busy_cnt_q   <= '0;
        end else if (state_q == ST_BUSY) begin
            busy_cnt_q   <= busy_cnt_q + 1'b1;
        end else if (evt.start) begin
            bit_cnt_q <= '0;
            drive_q   <= 1'b0;
        end else if (evt.stop) begin
            drive_q      <= 1'b0;
            commit_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (evt.rise) begin
                        shreg_q   <= {shreg_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        drive_q <= (state_q == ST_DEV) ? addr_match : 1'b1;
                        if (state_q == ST_DEV) begin
                            rw_q <= shreg_q[0];
                            hi_q <= shreg_q[1];
                            if (shreg_q[0]) begin
                                addr_q[ADDR_W-1] <= shreg_q[1];
                            end
                        end else if (state_q == ST_WORD) begin
                            addr_q <= {hi_q, shreg_q};
                        end else begin
                            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                        end
                    end
                end
                ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (evt.fall) begin
                        bit_cnt_q <= '0;
                        if ((state_q == ST_DEV_ACK) && rw_q) begin
                            tx_q    <= mem_rdata;
                            drive_q <= ~mem_rdata[7];
                        end else begin
                            drive_q <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (evt.rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (evt.fall) begin
                        drive_q <= (bit_cnt_q == 4'd8) ? 1'b0 : ~tx_q[tx_idx];
                    end
                end
                ST_RD_ACK: begin
                    if (evt.rise) begin
                        m_ack_q <= ~sda_s;
                        if (!sda_s) begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end else if (evt.fall) begin
                        bit_cnt_q <= '0;
                        if (m_ack_q) begin
                            tx_q    <= mem_rdata;
                            drive_q <= ~mem_rdata[7];
                        end else begin
                            drive_q <= 1'b0;
                        end
                    end
                end
                default: begin
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs toward the page buffer and the array.
    assign buf_clear   = (on_bus && evt.start) || ((state_q == ST_COMMIT) && commit_last);
    assign buf_wr_en   = (state_q == ST_WDATA) && byte_done && !evt.start && !evt.stop;
    assign buf_wr_idx  = addr_q[PAGE_W-1:0];
    assign buf_wr_data = shreg_q;
    assign buf_rd_idx  = commit_idx_q;
    assign mem_we      = (state_q == ST_COMMIT) && buf_rd_valid;
    assign mem_waddr   = {addr_q[ADDR_W-1 -: ROW_W], commit_idx_q};
    assign mem_wdata   = buf_rd_data;
    assign mem_raddr   = addr_q;
    assign drive_low   = drive_q;

    // The line stays released for the whole commit and write cycle.
    assert_quiet_in_write_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COMMIT) || (state_q == ST_BUSY)) |-> !drive_q);

    // The busy count never runs past its limit.
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (busy_cnt_q < BUSY_W'(WR_CYCLES)));

    // An address acknowledge needs type code and strap equality.
    assert_ack_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> ((shreg_q[7:4] == DEV_TYPE) && (shreg_q[3:2] == strap_i)));

    // The slave starts pulling the line only while SCL is low.
    assert_drive_on_low_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> !scl_s);

    // A commit is entered only from a stop condition.
    assert_commit_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COMMIT) |-> $past(evt.stop));

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import tw_eeprom_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         PAGE_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         WR_CYCLES   = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_drive_low
);

    tw_evt_t           evt;
    logic              scl_s, sda_s;
    logic [BYTE_W-1:0] mem_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic              mem_we;
    logic              buf_clear, buf_wr_en, buf_rd_valid, buf_any;
    logic [PAGE_W-1:0] buf_wr_idx, buf_rd_idx;
    logic [BYTE_W-1:0] buf_wr_data, buf_rd_data;

    tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    tw_page_buffer #(.PAGE_W(PAGE_W)) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (buf_wr_en),
        .wr_idx    (buf_wr_idx),
        .wr_data   (buf_wr_data),
        .rd_idx    (buf_rd_idx),
        .rd_data   (buf_rd_data),
        .rd_valid  (buf_rd_valid),
        .any_valid (buf_any)
    );

    tw_mem_array u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    tw_eeprom_fsm #(
        .DEV_TYPE  (DEV_TYPE),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .strap_i      (strap_i),
        .mem_rdata    (mem_rdata),
        .mem_raddr    (mem_raddr),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .buf_clear    (buf_clear),
        .buf_wr_en    (buf_wr_en),
        .buf_wr_idx   (buf_wr_idx),
        .buf_wr_data  (buf_wr_data),
        .buf_rd_idx   (buf_rd_idx),
        .buf_rd_data  (buf_rd_data),
        .buf_rd_valid (buf_rd_valid),
        .buf_any      (buf_any),
        .drive_low    (sda_drive_low)
    );

    // Array writes never coincide with the slave pulling the line.
    assert_no_drive_during_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !sda_drive_low);

endmodule

// File: tb/tw_eeprom_slave_tb.sv
module tw_eeprom_slave_tb;

    localparam int WRC = 300;
    localparam int Q   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       drv;
    logic       bus_sda;

    assign bus_sda = sda_m & ~drv;

    always #5 clk = ~clk;

    tw_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (bus_sda),
        .strap_i       (strap),
        .sda_drive_low (drv)
    );

    int errs = 0;
    int checks = 0;
    int mem [512];
    int cur = 0;
    int cyc = 0;
    int stop_cyc = -1000000;
    bit quiet_bad = 1'b0;

    // Per-clock reference comparison of the released line in the write cycle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if ((cyc - stop_cyc) < WRC && drv) quiet_bad <= 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        s = bus_sda; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            d = {d[6:0], s};
        end
        bit_io(~give_ack, s);
    endtask

    function automatic logic [7:0] dev(input int hi, input int rd);
        return {4'b1010, strap, hi[0], rd[0]};
    endfunction

    // Write n bytes (d0, d0+1, ...) at 9-bit address a, then probe the busy window.
    task automatic do_write(input int a, input int n, input int d0, input string req);
        logic ack;
        int pbuf [16];
        bit pval [16];
        int idx;
        for (int k = 0; k < 16; k++) pval[k] = 1'b0;
        start_c();
        send_byte(dev(a >> 8, 0), ack); chk(ack, "R3 address ack", ack, 1);
        send_byte(a[7:0], ack);         chk(ack, "R3 word ack", ack, 1);
        idx = a % 16;
        for (int i = 0; i < n; i++) begin
            send_byte(8'(d0 + i), ack);
            chk(ack, req, ack, 1);
            pbuf[idx] = (d0 + i) & 255;
            pval[idx] = 1'b1;
            idx = (idx + 1) % 16;
        end
        stop_c();
        stop_cyc = cyc;
        for (int k = 0; k < 16; k++) if (pval[k]) mem[(a & 'h1F0) | k] = pbuf[k];
        cur = (a & 'h1F0) | idx;
        // R6: own address is not acknowledged while the write cycle runs.
        start_c();
        send_byte(dev(0, 0), ack);
        chk(!ack, "R6 no ack while busy", ack, 0);
        stop_c();
        tick(WRC);
        chk(!quiet_bad, "R6 line released in write cycle", quiet_bad, 0);
        quiet_bad = 1'b0;
    endtask

    // Sequential read of n bytes with hi as address bit 8; last byte NACKed.
    task automatic do_read(input int hi, input int n, input string req);
        logic ack;
        logic [7:0] d;
        start_c();
        send_byte(dev(hi, 1), ack); chk(ack, "R7 read address ack", ack, 1);
        cur = (hi << 8) | (cur & 255);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == 8'(mem[cur]), req, d, mem[cur]);
            if (i < n - 1) cur = (cur + 1) % 512;
        end
        tick(1);
        chk(drv == 1'b0, "R8 released after NACK", drv, 0);
        stop_c();
    endtask

    // Dummy write to set the counter, then repeated start into a read.
    task automatic rand_read(input int a, input int n, input string req);
        logic ack;
        start_c();
        send_byte(dev(a >> 8, 0), ack); chk(ack, "R9 dummy address ack", ack, 1);
        send_byte(a[7:0], ack);         chk(ack, "R9 dummy word ack", ack, 1);
        cur = a;
        do_read(a >> 8, n, req);
    endtask

    initial begin
        tick(Q * 1000 * 40);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] d;
        for (int i = 0; i < 512; i++) mem[i] = 'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        chk(drv == 1'b0, "R1 line released after reset", drv, 0);
        do_read(0, 2, "R1 erased content from counter 0");

        // R2: wrong type code and wrong straps are not acknowledged
        start_c();
        send_byte(8'b1011_1000, ack); chk(!ack, "R2 wrong type code", ack, 0);
        send_byte(8'h00, ack);        chk(!ack, "R2 rest ignored", ack, 0);
        stop_c();
        start_c();
        send_byte(8'b1010_0100, ack); chk(!ack, "R2 wrong straps", ack, 0);
        stop_c();

        // R3 and R6: byte write with address bit 8 set
        do_write('h1A5, 1, 'h3C, "R3 data ack");
        start_c();
        send_byte(dev(0, 0), ack); chk(ack, "R6 ack after write cycle", ack, 1);
        stop_c();
        rand_read('h1A5, 1, "R3 byte stored at {bit1,word}");

        // R4 and R10: data followed by a repeated start is discarded
        start_c();
        send_byte(dev(0, 0), ack);
        send_byte(8'h10, ack);
        send_byte(8'h77, ack); chk(ack, "R4 data ack", ack, 1);
        start_c();
        send_byte(dev(0, 0), ack);
        send_byte(8'h10, ack);
        cur = 'h010;
        do_read(0, 1, "R4 no store without stop");
        start_c();
        send_byte(dev(0, 0), ack); chk(ack, "R4 no write cycle after dummy", ack, 1);
        stop_c();

        // R10: start in the middle of a word-address byte
        start_c();
        send_byte(dev(1, 0), ack);
        bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
        do_read(1, 1, "R10 restart mid byte");

        // R5: 20-byte page write wrapping inside the page at 0x0F0
        do_write('h0FA, 20, 'h40, "R5 page data ack");
        do_read(0, 1, "R5 counter after page write");
        rand_read('h0F0, 16, "R5 page contents after wrap");

        // R8: sequential read across the top of the array
        do_write('h1FF, 1, 'h5A, "R3 data ack top");
        rand_read('h1FF, 3, "R8 sequential wrap 0x1FF to 0x000");
        do_read(0, 1, "R8 no advance after NACK");

        // R9: dummy write then current read elsewhere
        rand_read('h0F5, 2, "R9 counter loaded by dummy write");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule